// File: doc/BRIEF.md
# Timer/Counter and Watchdog with Shared Prescaler

This block holds an 8-bit timer/counter and a watchdog, along with one power-of-two prescaler that only one of them can own at a time. The timer counts either instruction-cycle ticks or edges on an external count pin. The watchdog counts a free-running tick. When the base count of watchdog ticks ends, the watchdog times out. A time-out clears a timeout status bit. Depending on the sleep-state input, it also raises either a reset request or a wake request.

An 8-bit option register configures the block. It chooses the timer source, the counting edge of the external pin, the prescaler owner and the divide code. The owner of the prescaler runs at the ratio set by the divide code. The other user runs undivided. The timer's ratio table is offset by one step from the watchdog's table. Loading the timer restarts the prescaler while the timer owns it. Clear-watchdog and sleep strobes always restart the watchdog. They also restart the prescaler while the watchdog owns it.

Top module: `tmr_wdt_presc`

## Requirements
- R1: After reset, the timer reads 0, the option register reads FFh, the timeout status bit reads 1, and the overflow, reset-request and wake-request outputs are all 0.
- R2: A write strobe loads the option register, and the new value reads back on the next cycle. The field positions are: bit 5 is the source (1 = external pin, 0 = instruction ticks), bit 4 is the pin edge (1 = high-to-low, 0 = low-to-high), bit 3 is the owner (1 = watchdog, 0 = timer), and bits 2:0 are the divide code. Bits 7:6 are stored and have no function here.
- R3: When the owner bit is 0, the timer advances once per 2^(code+1) source events. Loading the timer restarts the prescaler from zero.
- R4: When the owner bit is 1, the timer advances on every source event, whatever the divide code.
- R5: When the source bit is 1, the timer counts only the pin edge that the edge bit selects, and instruction ticks have no effect on it.
- R6: A timer load sets the value on the next cycle and wins over an increment that falls in the same cycle.
- R7: A rollover from FFh to 00h raises the overflow output for exactly one cycle, in the same cycle the timer first reads 00h.
- R8: When the owner bit is 0, the watchdog times out after WDT_BASE ticks, whatever the divide code. When the owner bit is 1, it times out after WDT_BASE*2^code ticks.
- R9: A clear-watchdog or sleep strobe restarts the watchdog count and suppresses a time-out that would fall in the same cycle. It restarts the prescaler only when the owner bit is 1.
- R10: A time-out drives the timeout status bit to 0. A clear-watchdog or sleep strobe sets it back to 1.
- R11: A time-out pulses the reset request for one cycle when the sleep-state input is 0, and pulses the wake request for one cycle when it is 1. The two never pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| icyc_en | input | 1 | Instruction-cycle tick, one clock wide |
| ext_pin | input | 1 | External count pin, asynchronous |
| wdt_tick | input | 1 | Free-running watchdog tick, one clock wide |
| opt_we | input | 1 | Option register write strobe |
| opt_wdata | input | 8 | Option register write data |
| tmr_we | input | 1 | Timer load strobe |
| tmr_wdata | input | TW | Timer load value |
| clrwdt | input | 1 | Clear-watchdog strobe |
| sleep_cmd | input | 1 | Sleep-entry strobe |
| asleep | input | 1 | 1 while the device is in sleep |
| opt_q | output | 8 | Option register contents |
| tmr_q | output | TW | Timer value |
| tmr_ovf | output | 1 | One-cycle timer rollover pulse |
| wdt_reset | output | 1 | One-cycle reset request on time-out |
| wdt_wake | output | 1 | One-cycle wake request on time-out |
| to_n | output | 1 | Timeout status, 0 after a time-out |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a timer load and a timer increment. The bench provokes it by raising the load strobe with the value FFh and an instruction tick in the same cycle. It then expects FFh to be held, and expects the next tick to roll over with a single overflow pulse. The second pair is a clear-watchdog strobe and the final tick of the watchdog period. The bench provokes it by driving both together. It then expects no time-out in that cycle, and expects the next time-out after exactly one more full period.

// File: rtl/tw_pkg.sv
package tw_pkg;
   typedef struct packed {
      logic       spare7;
      logic       spare6;
      logic       src_ext;
      logic       edge_fall;
      logic       own_wdt;
      logic [2:0] rate;
   } opt_t;
endpackage

// File: rtl/tw_edge.sv
module tw_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic fall_sel,
   output logic edge_o
);
   logic [SYNC_STAGES-1:0] sh;
   logic                   prev;

   always_ff @(posedge clk) begin
      if (!rst_n) sh[0] <= 1'b0;
      else        sh[0] <= pin;
   end

   for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n) sh[i] <= 1'b0;
         else        sh[i] <= sh[i-1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= sh[SYNC_STAGES-1];
   end

   assign edge_o = fall_sel ? (prev & ~sh[SYNC_STAGES-1])
                            : (~prev & sh[SYNC_STAGES-1]);
endmodule

// File: rtl/tw_prescaler.sv
module tw_prescaler #(
   parameter int PW = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       inc,
   input  logic       clr,
   input  logic [3:0] tap,
   output logic       tick_o
);
   logic [PW-1:0] cnt;
   logic [PW-1:0] mask;

   for (genvar i = 0; i < PW; i++) begin : g_mask
      assign mask[i] = (int'(tap) > i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
   end

   // tap = 0 passes every event; tap = n emits once per 2^n events
   assign tick_o = inc & ((cnt & mask) == mask);
endmodule

// File: rtl/tw_timer.sv
module tw_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          we,
   input  logic [TW-1:0] wdata,
   output logic [TW-1:0] q,
   output logic          ovf
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q   <= '0;
         ovf <= 1'b0;
      end else if (we) begin
         q   <= wdata;
         ovf <= 1'b0;
      end else begin
         ovf <= inc & (q == '1);
         if (inc) q <= q + 1'b1;
      end
   end
endmodule

// File: rtl/tw_wdt.sv
module tw_wdt #(
   parameter int WDT_BASE = 18000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic clr,
   output logic done_o
);
   localparam int CW = (WDT_BASE > 1) ? $clog2(WDT_BASE) : 1;
   localparam logic [CW-1:0] LAST = CW'(WDT_BASE - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (tick) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
   end

   assign done_o = tick & (cnt == LAST);
endmodule

// File: rtl/tmr_wdt_presc.sv
module tmr_wdt_presc
   import tw_pkg::*;
#(
   parameter int TW          = 8,
   parameter int PW          = 8,
   parameter int WDT_BASE    = 18000,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          icyc_en,
   input  logic          ext_pin,
   input  logic          wdt_tick,
   input  logic          opt_we,
   input  logic [7:0]    opt_wdata,
   input  logic          tmr_we,
   input  logic [TW-1:0] tmr_wdata,
   input  logic          clrwdt,
   input  logic          sleep_cmd,
   input  logic          asleep,
   output logic [7:0]    opt_q,
   output logic [TW-1:0] tmr_q,
   output logic          tmr_ovf,
   output logic          wdt_reset,
   output logic          wdt_wake,
   output logic          to_n
);
   if (PW < 8) begin : g_bad_pw
      $error("PW must cover the largest timer ratio of 2^8");
   end
   if (TW < 1) begin : g_bad_tw
      $error("TW must be at least 1");
   end
   if (WDT_BASE < 1) begin : g_bad_base
      $error("WDT_BASE must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   opt_t opt_r;
   logic ext_edge, tmr_src, wd_clr, base_done;
   logic pre_in, pre_clr, pre_tick, tmr_inc, wd_post, to_now, to_q;
   logic [3:0] tap;

   always_ff @(posedge clk) begin
      if (!rst_n)      opt_r <= '1;
      else if (opt_we) opt_r <= opt_t'(opt_wdata);
   end
   assign opt_q = opt_r;

   tw_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin(ext_pin),
      .fall_sel(opt_r.edge_fall), .edge_o(ext_edge)
   );

   assign tmr_src = opt_r.src_ext ? ext_edge : icyc_en;
   assign wd_clr  = clrwdt | sleep_cmd;

   tw_wdt #(.WDT_BASE(WDT_BASE)) u_wdt (
      .clk(clk), .rst_n(rst_n), .tick(wdt_tick), .clr(wd_clr), .done_o(base_done)
   );

   // owner selection: timer table is one step above the watchdog table
   assign pre_in  = opt_r.own_wdt ? base_done : tmr_src;
   assign pre_clr = opt_r.own_wdt ? wd_clr    : tmr_we;
   assign tap     = opt_r.own_wdt ? {1'b0, opt_r.rate} : ({1'b0, opt_r.rate} + 4'd1);

   tw_prescaler #(.PW(PW)) u_pre (
      .clk(clk), .rst_n(rst_n), .inc(pre_in), .clr(pre_clr),
      .tap(tap), .tick_o(pre_tick)
   );

   assign tmr_inc = opt_r.own_wdt ? tmr_src  : pre_tick;
   assign wd_post = opt_r.own_wdt ? pre_tick : base_done;
   assign to_now  = wd_post & ~wd_clr;

   tw_timer #(.TW(TW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .inc(tmr_inc), .we(tmr_we),
      .wdata(tmr_wdata), .q(tmr_q), .ovf(tmr_ovf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         to_q <= 1'b0;
         to_n <= 1'b1;
      end else begin
         to_q <= to_now;
         if (wd_clr)      to_n <= 1'b1;
         else if (to_now) to_n <= 1'b0;
      end
   end

   assign wdt_reset = to_q & ~asleep;
   assign wdt_wake  = to_q & asleep;
endmodule

// File: rtl/tw_checker.sv
module tw_checker #(
   parameter int TW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          opt_we,
   input logic [7:0]    opt_wdata,
   input logic          tmr_we,
   input logic [TW-1:0] tmr_wdata,
   input logic          clrwdt,
   input logic          sleep_cmd,
   input logic [7:0]    opt_q,
   input logic [TW-1:0] tmr_q,
   input logic          tmr_ovf,
   input logic          wdt_reset,
   input logic          wdt_wake,
   input logic          to_n
);
   p_opt_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      opt_we |=> opt_q == $past(opt_wdata));
   p_load_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_we |=> tmr_q == $past(tmr_wdata));
   p_ovf_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ovf |-> tmr_q == '0);
   p_ovf_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ovf |=> !tmr_ovf);
   p_clr_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clrwdt || sleep_cmd) |=> !(wdt_reset || wdt_wake));
   p_to_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wdt_reset || wdt_wake) |-> !to_n);
   p_clr_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clrwdt || sleep_cmd) |=> to_n);
   p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wdt_reset, wdt_wake}));
endmodule

bind tmr_wdt_presc tw_checker #(.TW(TW)) u_chk (
   .clk(clk), .rst_n(rst_n), .opt_we(opt_we), .opt_wdata(opt_wdata),
   .tmr_we(tmr_we), .tmr_wdata(tmr_wdata), .clrwdt(clrwdt),
   .sleep_cmd(sleep_cmd), .opt_q(opt_q), .tmr_q(tmr_q), .tmr_ovf(tmr_ovf),
   .wdt_reset(wdt_reset), .wdt_wake(wdt_wake), .to_n(to_n)
);

// File: tb/tb_tmr_wdt_presc.sv
module tb_tmr_wdt_presc;
   localparam int BASE = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic icyc_en = 0, ext_pin = 0, wdt_tick = 0, opt_we = 0, tmr_we = 0;
   logic clrwdt = 0, sleep_cmd = 0, asleep = 0;
   logic [7:0] opt_wdata = 0, tmr_wdata = 0;
   logic [7:0] opt_q, tmr_q;
   logic tmr_ovf, wdt_reset, wdt_wake, to_n;

   int n_chk = 0, n_bad = 0, ovf_cnt = 0;

   always #10 clk = ~clk;

   tmr_wdt_presc #(.TW(8), .PW(8), .WDT_BASE(BASE), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .icyc_en(icyc_en), .ext_pin(ext_pin),
      .wdt_tick(wdt_tick), .opt_we(opt_we), .opt_wdata(opt_wdata),
      .tmr_we(tmr_we), .tmr_wdata(tmr_wdata), .clrwdt(clrwdt),
      .sleep_cmd(sleep_cmd), .asleep(asleep), .opt_q(opt_q), .tmr_q(tmr_q),
      .tmr_ovf(tmr_ovf), .wdt_reset(wdt_reset), .wdt_wake(wdt_wake), .to_n(to_n)
   );

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr_opt(logic [7:0] v);
      opt_wdata = v; opt_we = 1; @(negedge clk); opt_we = 0;
   endtask

   task automatic wr_tmr(logic [7:0] v);
      tmr_wdata = v; tmr_we = 1; @(negedge clk); tmr_we = 0;
   endtask

   task automatic icyc(int n);
      for (int i = 0; i < n; i++) begin
         icyc_en = 1; @(negedge clk);
         if (tmr_ovf) ovf_cnt++;
      end
      icyc_en = 0;
   endtask

   task automatic do_clr();
      clrwdt = 1; @(negedge clk); clrwdt = 0;
   endtask

   // ticks until a time-out request appears; returns count or -1
   task automatic ticks_to_timeout(int limit, output int cnt);
      cnt = -1;
      for (int i = 1; i <= limit; i++) begin
         wdt_tick = 1; @(negedge clk); wdt_tick = 0;
         if (wdt_reset || wdt_wake) begin cnt = i; break; end
      end
   endtask

   initial begin
      #4_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int t;
      repeat (3) @(negedge clk);
      rst_n = 1; @(negedge clk);
      // R1
      check("R1 timer", tmr_q, 0);
      check("R1 option", opt_q, 8'hFF);
      check("R1 to_n", to_n, 1);
      check("R1 pulses", {tmr_ovf, wdt_reset, wdt_wake}, 0);

      // R2 readback
      wr_opt(8'hA5); check("R2 readback", opt_q, 8'hA5);

      // R3 sweep of timer ratios, internal source, timer owns prescaler
      for (int k = 0; k < 8; k++) begin
         wr_opt(8'(k)); wr_tmr(0); ovf_cnt = 0;
         icyc(600);
         check($sformatf("R3 code%0d value", k), tmr_q, (600 >> (k+1)) % 256);
         check($sformatf("R7 code%0d ovf count", k), ovf_cnt, (600 >> (k+1)) / 256);
      end

      // R3 load restarts prescaler (ratio 8)
      wr_opt(8'h02); wr_tmr(0); icyc(5); wr_tmr(10); icyc(7);
      check("R3 load clears prescaler", tmr_q, 10);
      icyc(1); check("R3 after full period", tmr_q, 11);

      // R9 clear-watchdog leaves timer-owned prescaler alone
      wr_opt(8'h02); wr_tmr(0); icyc(5); do_clr(); icyc(3);
      check("R9 prescaler kept", tmr_q, 1);

      // R4 watchdog owns prescaler: timer 1:1 for any code
      for (int k = 0; k < 8; k += 7) begin
         wr_opt(8'h08 | 8'(k)); wr_tmr(0); icyc(37);
         check($sformatf("R4 code%0d", k), tmr_q, 37);
      end

      // R5 external edges, instruction ticks held active throughout
      for (int f = 0; f < 2; f++) begin
         ext_pin = 0;
         wr_opt(8'h28 | (f ? 8'h10 : 8'h00));
         repeat (6) @(negedge clk);
         wr_tmr(0);
         icyc_en = 1;
         for (int p = 0; p < 6; p++) begin
            ext_pin = 1; repeat (4) @(negedge clk);
            if (p != 5) begin ext_pin = 0; repeat (4) @(negedge clk); end
         end
         repeat (6) @(negedge clk);
         icyc_en = 0;
         check(f ? "R5 falling edges" : "R5 rising edges", tmr_q, f ? 5 : 6);
      end
      ext_pin = 0;

      // R6 load and increment in same cycle, then R7 rollover
      wr_opt(8'h08); repeat (4) @(negedge clk);
      tmr_wdata = 8'hFF; tmr_we = 1; icyc_en = 1; @(negedge clk);
      tmr_we = 0; icyc_en = 0;
      check("R6 load wins", tmr_q, 8'hFF);
      check("R7 no ovf on load", tmr_ovf, 0);
      icyc_en = 1; @(negedge clk); icyc_en = 0;
      check("R7 wrap value", tmr_q, 0);
      check("R7 ovf pulse", tmr_ovf, 1);
      @(negedge clk); check("R7 ovf one cycle", tmr_ovf, 0);

      // R8 timer-owned: watchdog 1:1 regardless of code
      asleep = 0;
      for (int k = 0; k < 8; k += 7) begin
         wr_opt(8'(k)); do_clr();
         ticks_to_timeout(1000, t);
         check($sformatf("R8 timer-owned code%0d", k), t, BASE);
         check("R11 reset request", {wdt_reset, wdt_wake}, 2'b10);
         check("R10 to_n cleared", to_n, 0);
         @(negedge clk); check("R11 one cycle", wdt_reset, 0);
      end
      do_clr(); check("R10 to_n restored", to_n, 1);

      // R8 watchdog-owned ratios
      for (int k = 0; k < 4; k++) begin
         wr_opt(8'h08 | 8'(k)); do_clr();
         ticks_to_timeout(1000, t);
         check($sformatf("R8 wdt-owned code%0d", k), t, BASE << k);
      end

      // R9 clear on the final tick
      wr_opt(8'h00); do_clr();
      ticks_to_timeout(BASE - 1, t);
      check("R9 no early timeout", t, -1);
      wdt_tick = 1; clrwdt = 1; @(negedge clk); wdt_tick = 0; clrwdt = 0;
      check("R9 suppressed", {wdt_reset, wdt_wake}, 0);
      ticks_to_timeout(1000, t);
      check("R9 full period after clear", t, BASE);

      // R9 sleep strobe restarts watchdog-owned prescaler; R11 wake
      asleep = 1;
      wr_opt(8'h09); do_clr();
      ticks_to_timeout(BASE + 2, t);
      sleep_cmd = 1; @(negedge clk); sleep_cmd = 0;
      ticks_to_timeout(1000, t);
      check("R9 sleep restart", t, 2 * BASE);
      check("R11 wake request", {wdt_reset, wdt_wake}, 2'b01);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule